// File: doc/BRIEF.md
# Asynchronous Tri-Level SAR Switching Controller

This block sequences a 10-bit differential successive-approximation conversion. Each capacitor array uses bottom plates that rest at the common-mode level and then step, once and in one direction only, to the upper or the lower reference. A sample strobe starts a conversion. It parks every switch at common mode and clears the result. The sign decision is then taken with nothing switched. After that, each decision moves the capacitor pair of the next lower weight to opposite references on the two arrays.

No conversion clock paces the steps. The controller raises a comparison request and holds it until the comparator reports ready. A settling wait follows before the next request. This wait is counted on a fast free-running clock and is longer for the heavy capacitors. If a comparator never answers, a timeout forces that decision to zero so the conversion always finishes. When the tenth decision lands, the result is published with a one-cycle done pulse. The result holds until the next strobe.

Top module: `sar_switch_ctrl`

## Requirements
- R1: After reset every switch code is common mode (2'b00), the comparison request and done are low and the result is zero.
- R2: A sample strobe, seen at a clock edge, sets every switch code on both arrays to common mode and clears the result. A conversion starts from that edge.
- R3: The first comparison request of a conversion (the sign bit, result bit 9) is raised while every switch code is still common mode.
- R4: When decision bit k (k from 9 down to 1) is accepted, capacitor position k-1 is switched. Positions run from weight 256 at index 8 to weight 1 at index 0. A decision of 1 sets the positive code to 2'b10 (lower reference) and the negative code to 2'b01 (upper reference). A decision of 0 does the reverse.
- R5: The code 2'b11 never appears. A switched capacitor keeps its code until the next sample strobe.
- R6: The result carries decision bit k in bit k, with the MSB decided first. For an ideal comparator, the result equals the input code.
- R7: Between the strobe, or an accepted decision, and the next request, the request stays low for a settling wait. The wait is 4 cycles when the next bit is 9..6, 2 cycles for bits 5..3 and 1 cycle for bits 2..0.
- R8: Once raised, the request stays high until the comparator reports ready or the timeout expires. It then drops.
- R9: If ready does not arrive within 16 cycles of the request, the decision is taken as 0. The request is high for exactly 16 cycles in that case, and the conversion continues.
- R10: Done is high for exactly one cycle after the tenth decision, with the final result already valid. The result then holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock used for step timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sample strobe; resets switches and starts a conversion |
| cmp_rdy_i | input | 1 | Comparator finished its decision |
| cmp_dec_i | input | 1 | Comparator decision, 1 when the positive side is higher |
| cmp_req_o | output | 1 | Self-timed comparison request |
| swp_o | output | 18 | Positive-array switch codes, 2 bits per position, position i at bits 2i+1:2i |
| swn_o | output | 18 | Negative-array switch codes, same layout |
| result_o | output | 10 | Conversion result |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Every input code from 0 to 1023 is converted against a comparator model. The model derives its threshold from the switch codes the block actually drives. A mirrored or misplaced capacitor move would therefore skew the threshold and corrupt codes near the affected weight. Comparator latency varies from code to code. The request-low gaps are measured per bit, so a wrong settling table shows up as a gap mismatch and a dropped request shows up as a missing decision. Two timeout runs are included: a silent comparator, and one that stays silent for a single bit. A timeout that stalled, fired early, or forced 1 would give a wrong request width or a wrong final code.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      SW_CM   = 2'b00,
      SW_UP   = 2'b01,
      SW_LOW  = 2'b10,
      SW_BAD  = 2'b11
   } sw_code_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_SETTLE = 2'b01,
      ST_CMP    = 2'b10
   } sar_state_e;
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
   parameter int SW  = 3,
   parameter int TMO = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [SW-1:0] len_i,
   input  logic          settle_en_i,
   input  logic          cmp_en_i,
   output logic          settle_done_o,
   output logic          timeout_o
);
   localparam int TW = $clog2(TMO > 1 ? TMO : 2);

   logic [SW-1:0] scnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              scnt <= '0;
      else if (load_i)         scnt <= len_i;
      else if (settle_en_i && scnt != '0) scnt <= scnt - 1'b1;
   end

   assign settle_done_o = settle_en_i && (scnt == '0);

   generate
      if (TMO > 0) begin : g_tmo
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          tcnt <= '0;
            else if (!cmp_en_i)  tcnt <= '0;
            else if (tcnt != TW'(TMO - 1)) tcnt <= tcnt + 1'b1;
         end
         assign timeout_o = cmp_en_i && (tcnt == TW'(TMO - 1));

         assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_en_i && !timeout_o |=> tcnt != '0 || !cmp_en_i);
      end else begin : g_no_tmo
         assign timeout_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sar_cap_cell.sv
module sar_cap_cell
   import sar_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic       set_i,
   input  logic       dec_i,
   output logic [1:0] p_o,
   output logic [1:0] n_o
);
   sw_code_e p_q, n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= SW_CM;
         n_q <= SW_CM;
      end else if (clear_i) begin
         p_q <= SW_CM;
         n_q <= SW_CM;
      end else if (set_i) begin
         p_q <= dec_i ? SW_LOW : SW_UP;
         n_q <= dec_i ? SW_UP  : SW_LOW;
      end
   end

   assign p_o = p_q;
   assign n_o = n_q;

   assert_no_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      p_q != SW_BAD && n_q != SW_BAD);
   assert_hold_switched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (p_q != SW_CM) && !clear_i |=> $stable(p_q) && $stable(n_q));
   assert_pair_opposite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (p_q == SW_CM) == (n_q == SW_CM) && (p_q == SW_CM || p_q != n_q));
endmodule

// File: rtl/sar_switch_ctrl.sv
module sar_switch_ctrl
   import sar_pkg::*;
#(
   parameter int NBITS    = 10,
   parameter int TMO      = 16,
   parameter int DLY_HI   = 4,
   parameter int DLY_MID  = 2,
   parameter int DLY_LO   = 1,
   parameter int HI_FROM  = 6,
   parameter int MID_FROM = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_i,
   input  logic                 cmp_rdy_i,
   input  logic                 cmp_dec_i,
   output logic                 cmp_req_o,
   output logic [2*NBITS-3:0]   swp_o,
   output logic [2*NBITS-3:0]   swn_o,
   output logic [NBITS-1:0]     result_o,
   output logic                 done_o
);
   localparam int NC = NBITS - 1;
   localparam int IW = $clog2(NBITS);
   localparam int SW = $clog2(DLY_HI + 1);

   generate
      if (NBITS < 2)                 begin : g_chk_n   $error("NBITS must be at least 2"); end
      if (DLY_LO < 1)                begin : g_chk_d   $error("settling delays must be at least 1"); end
      if (DLY_HI < DLY_MID || DLY_MID < DLY_LO) begin : g_chk_o $error("settling delays must not grow toward the LSB"); end
      if (TMO == 1)                  begin : g_chk_t   $error("TMO must be 0 or at least 2"); end
   endgenerate

   function automatic int dly_of(input int idx);
      if (idx >= HI_FROM)       return DLY_HI;
      else if (idx >= MID_FROM) return DLY_MID;
      else                      return DLY_LO;
   endfunction

   sar_state_e       state;
   logic [IW-1:0]    bidx;
   logic [IW-1:0]    nxt_idx;
   logic [SW-1:0]    len;
   logic             settle_done, timeout, accept, dec, load;

   assign accept  = (state == ST_CMP) && (cmp_rdy_i || timeout) && !sample_i;
   assign dec     = cmp_rdy_i && cmp_dec_i;
   assign nxt_idx = sample_i ? IW'(NBITS - 1) : bidx - 1'b1;
   assign len     = SW'(dly_of(int'(nxt_idx)) - 1);
   assign load    = sample_i || (accept && bidx != '0);

   sar_step_timer #(.SW(SW), .TMO(TMO)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (load),
      .len_i         (len),
      .settle_en_i   (state == ST_SETTLE),
      .cmp_en_i      (state == ST_CMP),
      .settle_done_o (settle_done),
      .timeout_o     (timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bidx     <= '0;
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (sample_i) begin
            state    <= ST_SETTLE;
            bidx     <= IW'(NBITS - 1);
            result_o <= '0;
         end else begin
            case (state)
               ST_SETTLE: if (settle_done) state <= ST_CMP;
               ST_CMP: if (accept) begin
                  result_o[bidx] <= dec;
                  if (bidx == '0) begin
                     state  <= ST_IDLE;
                     done_o <= 1'b1;
                  end else begin
                     state <= ST_SETTLE;
                     bidx  <= bidx - 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign cmp_req_o = (state == ST_CMP);

   genvar gi;
   generate
      for (gi = 0; gi < NC; gi++) begin : g_cap
         sar_cap_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (sample_i),
            .set_i   (accept && (bidx == IW'(gi + 1))),
            .dec_i   (dec),
            .p_o     (swp_o[2*gi+1:2*gi]),
            .n_o     (swn_o[2*gi+1:2*gi])
         );
      end
   endgenerate

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req_o && !cmp_rdy_i && !timeout && !sample_i |=> cmp_req_o);
   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !sample_i |=> $stable(result_o));
   assert_first_cmp_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req_o && bidx == IW'(NBITS - 1) |-> swp_o == '0 && swn_o == '0);
endmodule

// File: tb/tb_sar_switch_ctrl.sv
module tb_sar_switch_ctrl;
   localparam int NB = 10;
   localparam int NC = NB - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample = 1'b0, rdy = 1'b0, dec = 1'b0;
   logic req, done;
   logic [2*NC-1:0] swp, swn;
   logic [NB-1:0] res;

   int tests = 0, fails = 0, cyc = 0;

   always #10 clk = ~clk;

   sar_switch_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sample_i(sample), .cmp_rdy_i(rdy),
      .cmp_dec_i(dec), .cmp_req_o(req), .swp_o(swp), .swn_o(swn),
      .result_o(res), .done_o(done));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog: run hung, got %0d cycles expected < 190000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic int gap_of(input int b);
      return b >= 6 ? 4 : (b >= 3 ? 2 : 1);
   endfunction

   function automatic int thr_of(input logic [2*NC-1:0] p);
      int t = 512;
      for (int i = 0; i < NC; i++) begin
         if (p[2*i +: 2] == 2'b10)      t += (1 << i);
         else if (p[2*i +: 2] == 2'b01) t -= (1 << i);
      end
      return t;
   endfunction

   // mute: bit mask of decisions the comparator never answers
   task automatic convert(input int x, input int lat, input logic [NB-1:0] mute);
      logic [2*NC-1:0] ep = '0, en = '0;
      logic [NB-1:0] er = '0;
      int thr = 512;
      int gap, hi;
      logic bit_v;
      @(negedge clk) sample = 1'b1;
      @(negedge clk) sample = 1'b0;
      chk("R2 codes cleared", {swp, swn}, '0);
      chk("R2 result cleared", res, '0);
      for (int b = NB - 1; b >= 0; b--) begin
         gap = 0;
         while (!req && gap < 40) begin gap++; @(negedge clk); end
         chk($sformatf("R7 settle gap bit %0d", b), gap, gap_of(b));
         if (b == NB - 1) chk("R3 first compare unswitched", {swp, swn}, '0);
         chk($sformatf("R4 R5 codes at bit %0d", b), {swp, swn}, {ep, en});
         bit_v = mute[b] ? 1'b0 : (x >= thr);
         if (!mute[b]) chk($sformatf("R4 threshold bit %0d", b), thr_of(swp), thr);
         hi = 0;
         if (mute[b]) begin
            while (req && hi < 40) begin hi++; @(negedge clk); end
            chk($sformatf("R9 timeout width bit %0d", b), hi, 16);
         end else begin
            for (int l = 0; l < lat; l++) begin
               @(negedge clk);
               if (!req) begin
                  tests++; fails++;
                  $display("FAIL R8: request dropped, actual 0 expected 1");
               end
            end
            dec = (x >= thr_of(swp)); rdy = 1'b1;
            @(negedge clk) rdy = 1'b0; dec = 1'b0;
            chk($sformatf("R8 request released bit %0d", b), req, 1'b0);
         end
         er[b] = bit_v;
         if (b > 0) begin
            ep[2*(b-1) +: 2] = bit_v ? 2'b10 : 2'b01;
            en[2*(b-1) +: 2] = bit_v ? 2'b01 : 2'b10;
            thr += bit_v ? (1 << (b-1)) : -(1 << (b-1));
         end
      end
      chk("R10 done pulse", done, 1'b1);
      chk("R6 result", res, er);
      chk("R5 final codes", {swp, swn}, {ep, en});
      @(negedge clk);
      chk("R10 done single", done, 1'b0);
      @(negedge clk); @(negedge clk);
      chk("R10 result held", res, er);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset codes", {swp, swn}, '0);
      chk("R1 reset req/done", {req, done}, 2'b00);
      chk("R1 reset result", res, '0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int x = 0; x < 1024; x++) convert(x, x % 4, '0);
      convert(1023, 1, 10'h3FF);            // R9 silent comparator: code 0
      convert(1023, 2, 10'h020);            // R9 bit 5 silent: 1023 - 32
      convert(600, 0, 10'h200);             // R9 silent sign bit
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule